// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block is the digital control core for one leg of a three-phase inverter gate driver. It receives active-high high-side and low-side PWM commands, an active-low shutdown level, a fault-force line from the protection block, a supply undervoltage flag and a separate high-side undervoltage flag. From these it produces the two gate enables of the leg. It never drives both enables at once, and it leaves a dead time whenever one side hands over to the other.

The PWM commands pass through a two-flop synchronizer. A decoder then resolves them into one of three leg requests: off, high side or low side. A dead-time stage counts the clock cycles during which both enables have been low. It lets a new enable rise only when that count reaches the dead-time length. The dead-time length is derived from a nanosecond parameter and the clock frequency.

Shutdown, supply undervoltage and high-side undervoltage act as overrides. They pull the leg off at the next clock edge and hold the dead-time counter at zero. The fault line also masks both outputs in the same cycle, without waiting for a register.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `sd_ni` is low at a rising clock edge, both gate outputs are low after that edge, whatever the commands are.
- R2: With `sd_ni` high and both commands high (interlock), both outputs are low. The command is seen at the outputs three rising edges after it is applied.
- R3: With `sd_ni` high and both commands low, both outputs are low.
- R4: With `sd_ni` high and only `lo_cmd_i` high, `ls_gate_o` is high and `hs_gate_o` is low once the dead time has elapsed.
- R5: With `sd_ni` high and only `hi_cmd_i` high, `hs_gate_o` is high and `ls_gate_o` is low once the dead time has elapsed.
- R6: When one output falls during a handover, the opposite output rises exactly DT rising edges later. DT = ceil(DEAD_NS*CLK_MHZ/1000), which is 18 cycles by default. Neither output ever rises after fewer than DT consecutive cycles with both outputs low.
- R7: A high `uv_i` at a rising edge forces both outputs low after that edge.
- R8: A high `hs_uv_i` blocks only the high side: `hs_gate_o` is low after the edge. An active low-side output is not affected.
- R9: A high `fault_i` forces both outputs low in the same cycle it is asserted.
- R10: Once an override (shutdown, undervoltage or fault) is removed, the output rises at the DT-th rising edge after removal, not earlier.
- R11: While `rst_ni` is low both outputs are low. After reset is released, the first enable rises at the DT-th rising edge.
- R12: `hs_gate_o` and `ls_gate_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cmd_i | input | 1 | High-side PWM command, active high, asynchronous |
| lo_cmd_i | input | 1 | Low-side PWM command, active high, asynchronous |
| sd_ni | input | 1 | Shutdown, active low, synchronous level |
| uv_i | input | 1 | Supply undervoltage flag from the hysteretic monitor |
| hs_uv_i | input | 1 | High-side supply undervoltage flag |
| fault_i | input | 1 | Fault force from protection, immediate off |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
Each result has its own latency. A command change reaches the outputs at the third rising edge (two synchronizer flops, then the gate register). Shutdown and the undervoltage flags act at the first edge. The fault mask acts in the same cycle, before any edge. After a drop, a rise comes DT edges later. The bench changes inputs on falling edges and counts falling edges to know how many rising edges have passed. It samples exactly one edge before and at each expected transition, and it checks the fault mask one time unit after the fault is driven. The table-driven part holds each vector for 25 cycles, which is longer than the sync delay plus the dead time, so only settled values are compared.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // bit 0 = high-side enable, bit 1 = low-side enable
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HS  = 2'b01,
    LEG_LS  = 2'b10
  } leg_e;

  function automatic int unsigned dt_cycles(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[i] <= '0;
        else         st_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[i] <= '0;
        else         st_q[i] <= st_q[i-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_gate_pkg::*;
(
  input  logic hi_i,
  input  logic lo_i,
  input  logic sd_ni,
  input  logic uv_i,
  input  logic hs_uv_i,
  input  logic fault_i,
  output leg_e req_o,
  output logic ovr_o
);

  leg_e raw;

  always_comb begin
    unique case ({hi_i, lo_i})
      2'b10:   raw = LEG_HS;
      2'b01:   raw = LEG_LS;
      default: raw = LEG_OFF;  // idle or interlock
    endcase
  end

  // high-side undervoltage only overrides a high-side request
  assign ovr_o = ~sd_ni | uv_i | fault_i | (hs_uv_i & (raw == LEG_HS));
  assign req_o = ovr_o ? LEG_OFF : raw;

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_gate_pkg::*;
#(
  parameter int DT_CYC = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  leg_e req_i,
  input  logic ovr_i,
  output leg_e gate_o
);

  localparam int CW = $clog2(DT_CYC + 1);
  localparam logic [CW-1:0] DT_MAX = CW'(DT_CYC);

  leg_e          gate_q, gate_d;
  logic [CW-1:0] cnt_q, cnt_d, elapsed;

  // low cycles completed including the current one, saturating
  assign elapsed = (cnt_q >= DT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (ovr_i) begin
      gate_d = LEG_OFF;
      cnt_d  = '0;
    end else if (gate_q != LEG_OFF) begin
      if (req_i != gate_q) begin
        gate_d = LEG_OFF;
        cnt_d  = '0;
      end
    end else begin
      cnt_d = elapsed;
      if (elapsed >= DT_MAX && req_i != LEG_OFF) gate_d = req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= LEG_OFF;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int unsigned DEAD_NS     = 180,
  parameter int unsigned CLK_MHZ     = 100,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic sd_ni,
  input  logic uv_i,
  input  logic hs_uv_i,
  input  logic fault_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);

  localparam int DT_CYC = int'(dt_cycles(DEAD_NS, CLK_MHZ));

  logic [1:0] cmd_s;
  leg_e       req, gate;
  logic       ovr;

  hb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({hi_cmd_i, lo_cmd_i}),
    .q_o    (cmd_s)
  );

  hb_decode u_dec (
    .hi_i    (cmd_s[1]),
    .lo_i    (cmd_s[0]),
    .sd_ni   (sd_ni),
    .uv_i    (uv_i),
    .hs_uv_i (hs_uv_i),
    .fault_i (fault_i),
    .req_o   (req),
    .ovr_o   (ovr)
  );

  hb_deadtime #(.DT_CYC(DT_CYC)) u_dt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .ovr_i  (ovr),
    .gate_o (gate)
  );

  // fault path bypasses the register
  assign hs_gate_o = gate[0] & ~fault_i;
  assign ls_gate_o = gate[1] & ~fault_i;

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int DT_CYC = 18
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hi_cmd_i,
  input logic lo_cmd_i,
  input logic sd_ni,
  input logic uv_i,
  input logic hs_uv_i,
  input logic fault_i,
  input logic hs_gate_o,
  input logic ls_gate_o
);

  localparam int CW = $clog2(DT_CYC + 1);
  localparam logic [CW-1:0] DT_MAX = CW'(DT_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      low_cnt <= '0;
    else if (hs_gate_o || ls_gate_o)  low_cnt <= '0;
    else if (low_cnt < DT_MAX)        low_cnt <= low_cnt + 1'b1;
  end

  assert_no_overlap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o));

  assert_sd_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_ni |=> (!hs_gate_o && !ls_gate_o));

  assert_uv_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (!hs_gate_o && !ls_gate_o));

  assert_hs_uv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_uv_i |=> !hs_gate_o);

  assert_fault_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (!hs_gate_o && !ls_gate_o));

  assert_interlock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hi_cmd_i && lo_cmd_i, 3) |-> (!hs_gate_o && !ls_gate_o));

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!hi_cmd_i && !lo_cmd_i, 3) |-> (!hs_gate_o && !ls_gate_o));

  // covers R10 and R11 as well: every rise follows a full low window
  assert_dead_time_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_gate_o) || $rose(ls_gate_o)) |-> (low_cnt >= DT_MAX));

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DT_CYC(DT_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hi_cmd_i  (hi_cmd_i),
  .lo_cmd_i  (lo_cmd_i),
  .sd_ni     (sd_ni),
  .uv_i      (uv_i),
  .hs_uv_i   (hs_uv_i),
  .fault_i   (fault_i),
  .hs_gate_o (hs_gate_o),
  .ls_gate_o (ls_gate_o)
);

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;

  localparam int DT   = (180 * 100 + 999) / 1000;  // 18 cycles at 100 MHz
  localparam int HOLD = 25;
  localparam int NV   = 11;
  // {hi, lo, sd_n, uv, hs_uv, exp_hs, exp_ls}
  localparam logic [6:0] VEC [NV] = '{
    7'b1010010,  // R5 high side only
    7'b0110001,  // R4 low side only
    7'b1110000,  // R2 interlock
    7'b0010000,  // R3 idle
    7'b1000000,  // R1 shutdown with high cmd
    7'b0100000,  // R1 shutdown with low cmd
    7'b1011000,  // R7 supply uv, high cmd
    7'b0111000,  // R7 supply uv, low cmd
    7'b1010100,  // R8 hs uv blocks high side
    7'b0110101,  // R8 hs uv leaves low side
    7'b1010010   // R5 recover
  };

  logic clk = 1'b0;
  logic rst_n, hi, lo, sd_n, uv, hs_uv, fault;
  logic hs, ls;
  int   n_run = 0, n_fail = 0, overlap = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  hb_gate_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_n), .hi_cmd_i (hi), .lo_cmd_i (lo),
    .sd_ni (sd_n), .uv_i (uv), .hs_uv_i (hs_uv), .fault_i (fault),
    .hs_gate_o (hs), .ls_gate_o (ls)
  );

  always @(negedge clk) if (rst_n && hs && ls) overlap++;

  function automatic string vec_tag(int i);
    case (i)
      0, 10:   return "R5";
      1:       return "R4";
      2:       return "R2";
      3:       return "R3";
      4, 5:    return "R1";
      6, 7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // {hs,ls} packed as 2*hs+ls
  function automatic int outs();
    return {30'd0, hs, ls};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R11: watchdog, actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hi = 1'b1; lo = 1'b0; sd_n = 1'b1;
    uv = 1'b0; hs_uv = 1'b0; fault = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 in reset", outs(), 0);
    rst_n = 1'b1;
    repeat (DT - 1) @(negedge clk);
    check("R11 before first rise", outs(), 0);
    @(negedge clk);
    check("R11 first rise", outs(), 2);

    for (int i = 0; i < NV; i++) begin
      {hi, lo, sd_n, uv, hs_uv} = VEC[i][6:2];
      repeat (HOLD) @(negedge clk);
      check(vec_tag(i), outs(), int'(VEC[i][1:0]));
    end
    sd_n = 1'b1; uv = 1'b0; hs_uv = 1'b0;

    // R6 exact handover HS -> LS
    hi = 1'b0; lo = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 hs held before sync", outs(), 2);
    @(negedge clk);
    check("R6 hs dropped", outs(), 0);
    repeat (DT - 1) @(negedge clk);
    check("R6 ls held low", outs(), 0);
    @(negedge clk);
    check("R6 ls rises", outs(), 1);

    // R6 exact handover LS -> HS
    hi = 1'b1; lo = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 ls dropped", outs(), 0);
    repeat (DT - 1) @(negedge clk);
    check("R6 hs held low", outs(), 0);
    @(negedge clk);
    check("R6 hs rises", outs(), 2);

    // R9 fault acts in the same cycle, R10 resume timing
    fault = 1'b1;
    #1;
    check("R9 same-cycle mask", outs(), 0);
    @(negedge clk);
    fault = 1'b0;
    repeat (DT - 1) @(negedge clk);
    check("R10 fault release held", outs(), 0);
    @(negedge clk);
    check("R10 fault release resume", outs(), 2);

    // R1 shutdown pulse then R10 resume timing
    sd_n = 1'b0;
    @(negedge clk);
    check("R1 shutdown next edge", outs(), 0);
    sd_n = 1'b1;
    repeat (DT - 1) @(negedge clk);
    check("R10 shutdown release held", outs(), 0);
    @(negedge clk);
    check("R10 shutdown release resume", outs(), 2);

    // R8 hs uv while low side is active has no effect
    hi = 1'b0; lo = 1'b1;
    repeat (HOLD) @(negedge clk);
    hs_uv = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 ls unaffected", outs(), 1);
    hs_uv = 1'b0;

    check("R12 overlap count", overlap, 0);
    finish_run();
  end

endmodule